// File: doc/BRIEF.md
# SPI Character FIFO Port with Error and Request Flags

This block sits between a processor bus and the serial shifter of an SPI controller. One 32-bit data location serves both directions: a bus write places a character into a transmit queue, and a bus read takes the oldest character out of a receive queue. Both queues are 16 entries deep. The shifter uses a simple strobe handshake. It pulls characters from the transmit queue and pushes received characters into the receive queue.

Neither side is ever stalled. A character written to a full queue is thrown away, and a read from an empty queue returns stale data. Each such misuse sets a sticky error flag, and software clears these flags by writing ones to a mask. When programmed-I/O mode is selected, two level flags tell software how much it can write and how much it can read. Each flag compares a queue level against a 4-bit threshold. In DMA mode both flags are held low.

Event bit layout: bit 0 transmit overflow, bit 1 transmit underflow, bit 2 receive overflow, bit 3 receive underflow.

Top module: `spi_dport`

## Requirements
- R1: A bus write (`wr_en`) queues the low 24 bits of `wr_data` into the transmit queue, and bits 31:24 are discarded. Each `sh_tx_pop` on a non-empty queue presents the oldest queued character on `sh_tx_data` one cycle later, in write order.
- R2: Each `sh_rx_push` on a non-full receive queue stores `sh_rx_data`. A bus read (`rd_en`) on a non-empty queue presents the oldest character on `rd_data` one cycle later, with bits 31:24 zero.
- R3: Each queue holds exactly 16 characters before it reports full.
- R4: A bus write while the transmit queue holds 16 characters is dropped, and `events` bit 0 is set on the next cycle.
- R5: A bus read while the receive queue is empty leaves the queue unchanged, and `events` bit 3 is set on the next cycle.
- R6: A shifter push into a full receive queue is dropped and sets `events` bit 2. A shifter pull from an empty transmit queue sets `events` bit 1.
- R7: Event bits are sticky. A bit clears only in a cycle where `evt_clr_en` is high and the matching `evt_clr_mask` bit is 1; other bits are kept. If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: In programmed-I/O mode, `rx_req` is 1 when the receive level is at least `rx_thresh`, where a threshold of 0 counts as 1. The flag follows a level change one cycle after the level register.
- R9: In programmed-I/O mode, `tx_req` is 1 when the free transmit space (16 minus the level) is at least `tx_thresh`, where 0 counts as 1. It has the same one-cycle lag.
- R10: With `pio_mode` at 0, `tx_req` and `rx_req` are 0 from the next cycle onward.
- R11: After a synchronous reset, both queues are empty, and `events`, `tx_req`, `rx_req`, `rd_data` and `sh_tx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe to the data location |
| wr_data | input | 32 | Bus write data; the character is in the low 24 bits |
| rd_en | input | 1 | Bus read strobe to the data location |
| rd_data | output | 32 | Popped character, zero-extended, valid the cycle after `rd_en` |
| evt_clr_en | input | 1 | Write strobe for the event clear |
| evt_clr_mask | input | 4 | Ones select the event bits to clear |
| events | output | 4 | Sticky error flags |
| pio_mode | input | 1 | 1 = programmed I/O, 0 = DMA |
| tx_thresh | input | 4 | Transmit request threshold |
| rx_thresh | input | 4 | Receive request threshold |
| tx_req | output | 1 | Transmit space request flag |
| rx_req | output | 1 | Receive data request flag |
| sh_tx_pop | input | 1 | Shifter pulls a character |
| sh_tx_data | output | 24 | Character pulled, valid the cycle after `sh_tx_pop` |
| sh_rx_push | input | 1 | Shifter delivers a character |
| sh_rx_data | input | 24 | Character delivered by the shifter |

## Verification
The checker assumes the following about the inputs:
- Every strobe is a known value in each cycle after reset is released.
- The thresholds and `pio_mode` only change between operations.
- A bus write and a shifter pull, when both arrive in the same cycle, are handled one at a time by the level checks.

The stimulus respects these assumptions. It changes every input on the falling clock edge and pulses each strobe for exactly one cycle. It sets the thresholds and the mode while the queues are idle. It never raises `wr_en` and `sh_tx_pop` together.

// File: rtl/spi_dport_pkg.sv
package spi_dport_pkg;
  localparam int BUS_W  = 32;
  localparam int EV_N   = 4;
  localparam int EV_TXO = 0;
  localparam int EV_TXU = 1;
  localparam int EV_RXO = 2;
  localparam int EV_RXU = 3;
endpackage

// File: rtl/spi_dport_fifo.sv
module spi_dport_fifo #(
  parameter int DW = 24,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [AW:0]   level,
  output logic          full,
  output logic          empty,
  output logic          ovf,
  output logic          unf
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wp, rp;
  logic          do_push, do_pop;

  assign empty   = (wp == rp);
  assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign ovf     = push && full;
  assign unf     = pop && empty;
  assign level   = wp - rp;

  // storage without reset so a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_push) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      dout <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop) begin
        rp   <= rp + 1'b1;
        dout <= mem[rp[AW-1:0]];
      end
    end
  end
endmodule

// File: rtl/spi_dport_evt.sv
module spi_dport_evt #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr_en,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags
);
  logic [N-1:0] clr_vec;
  assign clr_vec = clr_en ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr_vec) | set;  // set wins over clear
  end
endmodule

// File: rtl/spi_dport_req.sv
module spi_dport_req #(
  parameter int AW   = 4,
  parameter int TH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pio,
  input  logic [AW:0]     tx_level,
  input  logic [AW:0]     rx_level,
  input  logic [TH_W-1:0] tx_th,
  input  logic [TH_W-1:0] rx_th,
  output logic            tx_req,
  output logic            rx_req
);
  localparam int CW = (TH_W > AW + 1) ? TH_W : AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(1 << AW);

  logic [CW-1:0] tx_eff, rx_eff, tx_free, rx_fill;

  assign tx_eff  = (tx_th == '0) ? CW'(1) : CW'(tx_th);
  assign rx_eff  = (rx_th == '0) ? CW'(1) : CW'(rx_th);
  assign tx_free = DEPTH_C - CW'(tx_level);
  assign rx_fill = CW'(rx_level);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_req <= 1'b0;
      rx_req <= 1'b0;
    end else begin
      tx_req <= pio && (tx_free >= tx_eff);
      rx_req <= pio && (rx_fill >= rx_eff);
    end
  end
endmodule

// File: rtl/spi_dport.sv
module spi_dport
  import spi_dport_pkg::*;
#(
  parameter int CHAR_W = 24,
  parameter int AW     = 4,
  parameter int TH_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              rd_en,
  output logic [BUS_W-1:0]  rd_data,
  input  logic              evt_clr_en,
  input  logic [EV_N-1:0]   evt_clr_mask,
  output logic [EV_N-1:0]   events,
  input  logic              pio_mode,
  input  logic [TH_W-1:0]   tx_thresh,
  input  logic [TH_W-1:0]   rx_thresh,
  output logic              tx_req,
  output logic              rx_req,
  input  logic              sh_tx_pop,
  output logic [CHAR_W-1:0] sh_tx_data,
  input  logic              sh_rx_push,
  input  logic [CHAR_W-1:0] sh_rx_data
);
  logic [AW:0]       tx_level, rx_level;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_ovf, tx_unf, rx_ovf, rx_unf;
  logic [CHAR_W-1:0] rx_dout;
  logic [EV_N-1:0]   ev_set;
  logic              unused_hi;

  assign unused_hi = ^wr_data[BUS_W-1:CHAR_W];

  spi_dport_fifo #(.DW(CHAR_W), .AW(AW)) tx_q (
    .clk(clk), .rst(rst),
    .push(wr_en), .din(wr_data[CHAR_W-1:0]),
    .pop(sh_tx_pop), .dout(sh_tx_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty),
    .ovf(tx_ovf), .unf(tx_unf)
  );

  spi_dport_fifo #(.DW(CHAR_W), .AW(AW)) rx_q (
    .clk(clk), .rst(rst),
    .push(sh_rx_push), .din(sh_rx_data),
    .pop(rd_en), .dout(rx_dout),
    .level(rx_level), .full(rx_full), .empty(rx_empty),
    .ovf(rx_ovf), .unf(rx_unf)
  );

  always_comb begin
    ev_set         = '0;
    ev_set[EV_TXO] = tx_ovf;
    ev_set[EV_TXU] = tx_unf;
    ev_set[EV_RXO] = rx_ovf;
    ev_set[EV_RXU] = rx_unf;
  end

  spi_dport_evt #(.N(EV_N)) evt_i (
    .clk(clk), .rst(rst), .set(ev_set),
    .clr_en(evt_clr_en), .clr_mask(evt_clr_mask), .flags(events)
  );

  spi_dport_req #(.AW(AW), .TH_W(TH_W)) req_i (
    .clk(clk), .rst(rst), .pio(pio_mode),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_th(tx_thresh), .rx_th(rx_thresh),
    .tx_req(tx_req), .rx_req(rx_req)
  );

  assign rd_data = BUS_W'(rx_dout);
endmodule

// File: rtl/spi_dport_chk.sv
module spi_dport_chk
  import spi_dport_pkg::*;
#(
  parameter int AW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic            rd_en,
  input logic            sh_tx_pop,
  input logic            sh_rx_push,
  input logic            evt_clr_en,
  input logic [EV_N-1:0] evt_clr_mask,
  input logic [EV_N-1:0] events,
  input logic            pio_mode,
  input logic            tx_req,
  input logic            rx_req,
  input logic [AW:0]     tx_level,
  input logic [AW:0]     rx_level,
  input logic            tx_full,
  input logic            tx_empty,
  input logic            rx_full,
  input logic            rx_empty
);
  localparam int DEPTH = 1 << AW;

  a_r3_level_bound: assert property (@(posedge clk) disable iff (rst)
    (tx_level <= (AW+1)'(DEPTH)) && (rx_level <= (AW+1)'(DEPTH)));

  a_r1_push_grows: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !tx_full && !sh_tx_pop) |=> (tx_level == $past(tx_level) + 1'b1));

  a_r4_tx_overflow: assert property (@(posedge clk) disable iff (rst)
    (wr_en && tx_full) |=> events[EV_TXO]);

  a_r5_rx_underflow: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rx_empty) |=> (events[EV_RXU] && rx_level == $past(rx_level)));

  a_r6_rx_overflow: assert property (@(posedge clk) disable iff (rst)
    (sh_rx_push && rx_full) |=> events[EV_RXO]);

  a_r6_tx_underflow: assert property (@(posedge clk) disable iff (rst)
    (sh_tx_pop && tx_empty) |=> events[EV_TXU]);

  a_r10_dma_quiet: assert property (@(posedge clk) disable iff (rst)
    !pio_mode |=> (!tx_req && !rx_req));

  for (genvar i = 0; i < EV_N; i++) begin : g_sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
      $fell(events[i]) |-> $past(evt_clr_en && evt_clr_mask[i]));
  end
endmodule

bind spi_dport spi_dport_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
  .sh_tx_pop(sh_tx_pop), .sh_rx_push(sh_rx_push),
  .evt_clr_en(evt_clr_en), .evt_clr_mask(evt_clr_mask), .events(events),
  .pio_mode(pio_mode), .tx_req(tx_req), .rx_req(rx_req),
  .tx_level(tx_level), .rx_level(rx_level),
  .tx_full(tx_full), .tx_empty(tx_empty),
  .rx_full(rx_full), .rx_empty(rx_empty)
);

// File: tb/spi_dport_tb_top.sv
module spi_dport_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 0, rd_en = 0, evt_clr_en = 0, pio_mode = 1;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  evt_clr_mask = '0, events;
  logic [3:0]  tx_thresh = '0, rx_thresh = '0;
  logic        tx_req, rx_req;
  logic        sh_tx_pop = 0, sh_rx_push = 0;
  logic [23:0] sh_tx_data, sh_rx_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  spi_dport dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data),
    .evt_clr_en(evt_clr_en), .evt_clr_mask(evt_clr_mask), .events(events),
    .pio_mode(pio_mode), .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
    .tx_req(tx_req), .rx_req(rx_req),
    .sh_tx_pop(sh_tx_pop), .sh_tx_data(sh_tx_data),
    .sh_rx_push(sh_rx_push), .sh_rx_data(sh_rx_data)
  );

  // {rx_side, pio, thresh[3:0], count[4:0], expected_req}
  localparam int NV = 14;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 1'b1, 4'd0,  5'd15, 1'b1},  // R9 th 0 acts as 1, one slot free
    {1'b0, 1'b1, 4'd0,  5'd16, 1'b0},  // R9 full
    {1'b0, 1'b1, 4'd8,  5'd8,  1'b1},  // R9 exactly 8 free
    {1'b0, 1'b1, 4'd8,  5'd9,  1'b0},  // R9 7 free
    {1'b0, 1'b1, 4'd15, 5'd1,  1'b1},  // R9
    {1'b0, 1'b1, 4'd15, 5'd2,  1'b0},  // R9
    {1'b0, 1'b0, 4'd1,  5'd0,  1'b0},  // R10 dma mode
    {1'b1, 1'b1, 4'd0,  5'd0,  1'b0},  // R8 empty
    {1'b1, 1'b1, 4'd0,  5'd1,  1'b1},  // R8 th 0 acts as 1
    {1'b1, 1'b1, 4'd5,  5'd4,  1'b0},  // R8
    {1'b1, 1'b1, 4'd5,  5'd5,  1'b1},  // R8
    {1'b1, 1'b1, 4'd15, 5'd15, 1'b1},  // R8
    {1'b1, 1'b1, 4'd15, 5'd14, 1'b0},  // R8
    {1'b1, 1'b0, 4'd1,  5'd16, 1'b0}   // R10 dma mode
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cpu_wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cpu_rd();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic sh_push(input logic [23:0] d);
    sh_rx_push = 1'b1; sh_rx_data = d;
    @(negedge clk);
    sh_rx_push = 1'b0;
  endtask

  task automatic sh_pop();
    sh_tx_pop = 1'b1;
    @(negedge clk);
    sh_tx_pop = 1'b0;
  endtask

  task automatic clr(input logic [3:0] m);
    evt_clr_en = 1'b1; evt_clr_mask = m;
    @(negedge clk);
    evt_clr_en = 1'b0; evt_clr_mask = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R11 reset state
    check("R11 events", 32'(events), 32'h0);
    check("R11 rd_data", rd_data, 32'h0);
    check("R11 sh_tx_data", 32'(sh_tx_data), 32'h0);
    pio_mode = 1'b0;
    @(negedge clk);
    check("R11 reqs", {30'h0, tx_req, rx_req}, 32'h0);

    // table walk: thresholds versus levels
    for (int v = 0; v < NV; v++) begin
      do_reset();
      pio_mode  = VEC[v][10];
      tx_thresh = VEC[v][9:6];
      rx_thresh = VEC[v][9:6];
      for (int k = 0; k < int'(VEC[v][5:1]); k++) begin
        if (VEC[v][11]) sh_push(24'(k));
        else            cpu_wr(32'(k));
      end
      repeat (2) @(negedge clk);
      if (VEC[v][11]) check("R8/R10 rx_req", 32'(rx_req), 32'(VEC[v][0]));
      else            check("R9/R10 tx_req", 32'(tx_req), 32'(VEC[v][0]));
    end

    // R1 order and upper bits dropped
    do_reset();
    pio_mode = 1'b1; tx_thresh = 4'd1; rx_thresh = 4'd1;
    cpu_wr(32'hFF12_3456);
    cpu_wr(32'hA5AB_CDEF);
    cpu_wr(32'h0000_0001);
    sh_pop(); check("R1 first", 32'(sh_tx_data), 32'h0012_3456);
    sh_pop(); check("R1 second", 32'(sh_tx_data), 32'h00AB_CDEF);
    sh_pop(); check("R1 third", 32'(sh_tx_data), 32'h0000_0001);
    check("R1 no error", 32'(events), 32'h0);

    // R2 receive path zero-extended
    sh_push(24'hFEDCBA);
    sh_push(24'h000042);
    cpu_rd(); check("R2 first", rd_data, 32'h00FE_DCBA);
    cpu_rd(); check("R2 second", rd_data, 32'h0000_0042);

    // R3/R4 transmit overflow and drop, R6 transmit underflow
    do_reset();
    for (int k = 0; k < 16; k++) cpu_wr(32'h100 + 32'(k));
    check("R3 16 fit", 32'(events), 32'h0);
    cpu_wr(32'h0000_0BAD);
    check("R4 tx overflow", 32'(events), 32'h1);
    for (int k = 0; k < 16; k++) sh_pop();
    check("R4 last kept", 32'(sh_tx_data), 32'h10F);
    check("R4 no underflow yet", 32'(events), 32'h1);
    sh_pop();
    check("R6 tx underflow", 32'(events), 32'h3);

    // R7 partial clear
    clr(4'b0001);
    check("R7 masked clear", 32'(events), 32'h2);

    // R3/R6 receive overflow, R5 receive underflow
    do_reset();
    for (int k = 0; k < 16; k++) sh_push(24'h200 + 24'(k));
    check("R3 rx 16 fit", 32'(events), 32'h0);
    sh_push(24'hBAD);
    check("R6 rx overflow", 32'(events), 32'h4);
    for (int k = 0; k < 16; k++) cpu_rd();
    check("R6 last kept", rd_data, 32'h20F);
    cpu_rd();
    check("R5 rx underflow", 32'(events), 32'hC);
    sh_push(24'h777);
    cpu_rd();
    check("R5 queue intact", rd_data, 32'h777);

    // R7 set wins over clear in same cycle
    rd_en = 1'b1; evt_clr_en = 1'b1; evt_clr_mask = 4'b1000;
    @(negedge clk);
    rd_en = 1'b0; evt_clr_en = 1'b0; evt_clr_mask = '0;
    check("R7 set wins", 32'(events), 32'hC);
    @(negedge clk);
    check("R7 sticky", 32'(events), 32'hC);
    clr(4'b1111);
    check("R7 clear all", 32'(events), 32'h0);

    finish_run();
  end
endmodule